// File: doc/BRIEF.md
# Backlight Dimming and Contrast Register Slave

This block is a two-wire bus slave that holds the two 8-bit settings of a display backlight controller: a contrast setting and a brightness setting. A host reaches it at 7-bit address 28h. The host uses a Write Byte transaction (address, command byte, data byte) to change a setting. It uses a Read Byte transaction (address, command byte, repeated START, address with the read bit, one data byte from the slave) to read one back.

The contrast setting goes out unchanged as an 8-bit code for a contrast DAC. The brightness setting uses inverted sense: a stored 00h is the brightest lamp and FFh the dimmest. Its upper five bits drive a 32-level dimming DAC. A suspend input overrides the dimming code with the dimmest value and leaves the stored settings alone. Both bus lines are sampled through synchronisers on the system clock. The slave only ever pulls the data line low.

Top module: `bkl_smb_regs`

## Requirements
- R1: After reset both settings hold 00h, `contrast_code` reads 00h, `dim_code` reads 00h and `sda_pull_low` is 0.
- R2: An address byte whose upper seven bits equal 28h is acknowledged. Any other address is not acknowledged, and the rest of that transaction changes nothing.
- R3: A Write Byte with command A9h stores the data byte as the contrast setting, and `contrast_code` then equals it over the full range 00h to FFh.
- R4: A Write Byte with command AAh stores the data byte as the brightness setting, and `dim_code` then equals bits 7:3 of it (00h gives 0, FFh gives 1Fh, and bits 2:0 have no effect).
- R5: A command byte other than A9h or AAh is not acknowledged. The data byte that follows is not acknowledged either, and both settings stay unchanged.
- R6: A Read Byte returns the setting selected by its command byte, most significant bit first, on the data line after the repeated START.
- R7: A STOP before a data byte is complete returns the slave to idle and leaves the settings unchanged. The next transaction is served normally.
- R8: While `suspend_in` is 1, `dim_code` is 1Fh. The stored brightness is kept, can be read back, and reappears on `dim_code` when `suspend_in` returns to 0.
- R9: `sda_pull_low` is 1 only in an acknowledge slot or while the slave sends a 0 data bit, and it is 0 when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull_low | output | 1 | 1 pulls the open-drain data line low |
| suspend_in | input | 1 | Forces the dimmest dimming code while 1 |
| contrast_code | output | 8 | Code to the contrast DAC, 00h lowest output |
| dim_code | output | 5 | Code to the dimming DAC, 1Fh dimmest |

## Verification
On every cycle the assertions check these things: the data line is pulled only in acknowledge or transmit states; a STOP always leads to idle with the line released; a START always leads to address reception; a register write lands in the selected entry; and suspend forces the dimmest code. Only the bench's bus scenarios can show what needs whole transactions. That covers address and command filtering with their acknowledge bits, the bit order of read data, recovery from a STOP in mid-byte, and brightness surviving a suspend period. The bench mixes seeded random writes and reads of both settings with directed corner values.

// File: rtl/bkl_smb_pkg.sv
package bkl_smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDAT, ST_ACK, ST_TX, ST_MACK, ST_WAIT
  } bus_state_e;
endpackage

// File: rtl/bkl_smb_sync.sv
module bkl_smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_in;
          sda_ff[0] <= sda_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_ff[STAGES-1] & ~scl_prev;
  assign scl_fall  = ~scl_ff[STAGES-1] & scl_prev;
  assign start_det = scl_ff[STAGES-1] & scl_prev & sda_prev & ~sda_ff[STAGES-1];
  assign stop_det  = scl_ff[STAGES-1] & scl_prev & ~sda_prev & sda_ff[STAGES-1];
endmodule

// File: rtl/bkl_smb_regfile.sv
module bkl_smb_regfile #(
  parameter int NREG   = 2,
  parameter int DATA_W = 8,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [SEL_W-1:0]             rd_sel,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NREG-1:0][DATA_W-1:0]  regs_o
);
  logic [NREG-1:0][DATA_W-1:0] mem;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) mem[g] <= '0;
      else if (wr_en && wr_sel == SEL_W'(g)) mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_sel];
  assign regs_o  = mem;

  // R3
  wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/bkl_smb_fsm.sv
module bkl_smb_fsm
  import bkl_smb_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h28,
  parameter logic [7:0] CMD_LO     = 8'hA9,
  parameter logic [7:0] CMD_HI     = 8'hAA,
  parameter int         BYTE_W     = 8,
  localparam int        CNT_W      = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_sel,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_pull_low
);
  bus_state_e        state, state_n, after_ack, after_ack_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] rx_sh, rx_sh_n, tx_sh, tx_sh_n;
  logic              ptr, ptr_n;
  logic              rx_phase;

  assign rx_phase = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDAT);

  always_comb begin
    state_n     = state;
    after_ack_n = after_ack;
    cnt_n       = cnt;
    rx_sh_n     = rx_sh;
    tx_sh_n     = tx_sh;
    ptr_n       = ptr;
    wr_en       = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
    end else if (rx_phase) begin
      if (scl_rise && cnt != CNT_W'(BYTE_W)) begin
        rx_sh_n = {rx_sh[BYTE_W-2:0], sda_s};
        cnt_n   = cnt + 1'b1;
      end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
        cnt_n = '0;
        unique case (state)
          ST_ADDR: begin
            if (rx_sh[BYTE_W-1:1] == SLAVE_ADDR) begin
              state_n     = ST_ACK;
              after_ack_n = rx_sh[0] ? ST_TX : ST_CMD;
            end else begin
              state_n = ST_WAIT;
            end
          end
          ST_CMD: begin
            if (rx_sh == CMD_LO || rx_sh == CMD_HI) begin
              state_n     = ST_ACK;
              after_ack_n = ST_WDAT;
              ptr_n       = (rx_sh == CMD_HI);
            end else begin
              state_n = ST_WAIT;
            end
          end
          default: begin
            wr_en       = 1'b1;
            state_n     = ST_ACK;
            after_ack_n = ST_WAIT;
          end
        endcase
      end
    end else begin
      unique case (state)
        ST_ACK: begin
          if (scl_fall) begin
            state_n = after_ack;
            cnt_n   = '0;
            if (after_ack == ST_TX) tx_sh_n = rd_data;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == CNT_W'(BYTE_W - 1)) begin
              state_n = ST_MACK;
            end else begin
              tx_sh_n = {tx_sh[BYTE_W-2:0], 1'b1};
              cnt_n   = cnt + 1'b1;
            end
          end
        end
        ST_MACK: if (scl_fall) state_n = ST_WAIT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      after_ack    <= ST_WAIT;
      cnt          <= '0;
      rx_sh        <= '0;
      tx_sh        <= '1;
      ptr          <= 1'b0;
      sda_pull_low <= 1'b0;
    end else begin
      state        <= state_n;
      after_ack    <= after_ack_n;
      cnt          <= cnt_n;
      rx_sh        <= rx_sh_n;
      tx_sh        <= tx_sh_n;
      ptr          <= ptr_n;
      sda_pull_low <= (state_n == ST_ACK) || (state_n == ST_TX && !tx_sh_n[BYTE_W-1]);
    end
  end

  assign rd_sel  = ptr;
  assign wr_data = rx_sh;

  // R9
  pull_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
    sda_pull_low |-> (state == ST_ACK || state == ST_TX));
  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_pull_low));
  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> state == ST_ADDR);
endmodule

// File: rtl/bkl_smb_regs.sv
module bkl_smb_regs #(
  parameter logic [6:0] SLAVE_ADDR  = 7'h28,
  parameter logic [7:0] CMD_CONTR   = 8'hA9,
  parameter logic [7:0] CMD_BRIGHT  = 8'hAA,
  parameter int         DATA_W      = 8,
  parameter int         DIM_W       = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull_low,
  input  logic              suspend_in,
  output logic [DATA_W-1:0] contrast_code,
  output logic [DIM_W-1:0]  dim_code
);
  localparam int NREG = 2;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, rd_sel;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [NREG-1:0][DATA_W-1:0] regs;

  bkl_smb_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bkl_smb_fsm #(
    .SLAVE_ADDR(SLAVE_ADDR), .CMD_LO(CMD_CONTR), .CMD_HI(CMD_BRIGHT), .BYTE_W(DATA_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .rd_sel(rd_sel), .wr_en(wr_en), .wr_data(wr_data), .sda_pull_low(sda_pull_low)
  );

  bkl_smb_regfile #(.NREG(NREG), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(rd_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .regs_o(regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      contrast_code <= '0;
      dim_code      <= '0;
    end else begin
      contrast_code <= regs[0];
      dim_code      <= suspend_in ? '1 : regs[1][DATA_W-1 -: DIM_W];
    end
  end

  // R8
  susp_dim_chk: assert property (@(posedge clk) disable iff (rst)
    $past(suspend_in) |-> dim_code == '1);
  // R1
  reset_code_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> contrast_code == '0);
endmodule

// File: tb/bkl_smb_regs_tb.sv
module bkl_smb_regs_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, susp = 1'b0;
  logic drv;
  logic [7:0] con;
  logic [4:0] dim;
  logic sda_line;
  int checks = 0, fails = 0;
  logic [7:0] mdl_con = 8'h00, mdl_bri = 8'h00;

  assign sda_line = m_sda & ~drv;
  always #4 clk = ~clk;

  bkl_smb_regs dut_i (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_pull_low(drv),
    .suspend_in(susp), .contrast_code(con), .dim_code(dim)
  );

  function automatic logic [4:0] exp_dim(logic [7:0] b, logic s);
    return s ? 5'h1F : b[7:3];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_bit(logic b);
    m_sda = b; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); b = sda_line; q(); m_scl = 1'b0; q();
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(nb);
    ack = ~nb;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    send_bit(1'b1);
  endtask

  task automatic wr_txn(logic [6:0] a, logic [7:0] c, logic [7:0] d,
                        output logic a1, output logic a2, output logic a3);
    bus_start();
    send_byte({a, 1'b0}, a1);
    send_byte(c, a2);
    send_byte(d, a3);
    bus_stop();
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_txn(logic [7:0] c, output logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    bus_start();
    send_byte({7'h28, 1'b0}, a1);
    send_byte(c, a2);
    bus_start();
    send_byte({7'h28, 1'b1}, a3);
    recv_byte(d);
    bus_stop();
    repeat (4) @(negedge clk);
    ok = a1 & a2 & a3;
  endtask

  task automatic check_outputs(string req);
    chk(req, con, mdl_con);
    chk(req, dim, exp_dim(mdl_bri, susp));
    chk({req, " idle release R9"}, drv, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic a1, a2, a3, ok;
    logic [7:0] rd;
    void'($urandom(32'h1F2E3D4C));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check_outputs("R1");

    // R3 contrast extremes
    wr_txn(7'h28, 8'hA9, 8'hFF, a1, a2, a3); mdl_con = 8'hFF;
    chk("R3 acks", {a1, a2, a3}, 3'b111);
    check_outputs("R3");
    wr_txn(7'h28, 8'hA9, 8'h00, a1, a2, a3); mdl_con = 8'h00;
    check_outputs("R3");
    // R4 brightness extremes and ignored low bits
    wr_txn(7'h28, 8'hAA, 8'hFF, a1, a2, a3); mdl_bri = 8'hFF;
    check_outputs("R4");
    wr_txn(7'h28, 8'hAA, 8'h07, a1, a2, a3); mdl_bri = 8'h07;
    check_outputs("R4");
    wr_txn(7'h28, 8'hAA, 8'h98, a1, a2, a3); mdl_bri = 8'h98;
    check_outputs("R4");

    // R2 wrong address
    wr_txn(7'h29, 8'hA9, 8'h55, a1, a2, a3);
    chk("R2 addr nack", {a1, a2, a3}, 3'b000);
    check_outputs("R2");
    wr_txn(7'h14, 8'hAA, 8'h00, a1, a2, a3);
    chk("R2 addr nack", a1, 0);
    check_outputs("R2");

    // R5 unknown command
    wr_txn(7'h28, 8'hAB, 8'h33, a1, a2, a3);
    chk("R5 acks", {a1, a2, a3}, 3'b100);
    check_outputs("R5");
    rd_txn(8'hA9, rd, ok); chk("R5 contrast kept", rd, mdl_con);
    rd_txn(8'hAA, rd, ok); chk("R5 brightness kept", rd, mdl_bri);

    // R6 read with a mixed bit pattern
    wr_txn(7'h28, 8'hA9, 8'hA5, a1, a2, a3); mdl_con = 8'hA5;
    rd_txn(8'hA9, rd, ok);
    chk("R6 acks", ok, 1);
    chk("R6 readback", rd, 8'hA5);

    // R7 stop in mid data byte
    bus_start();
    send_byte({7'h28, 1'b0}, a1);
    send_byte(8'hA9, a2);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    repeat (4) @(negedge clk);
    check_outputs("R7");
    wr_txn(7'h28, 8'hA9, 8'h3C, a1, a2, a3); mdl_con = 8'h3C;
    chk("R7 recovers", {a1, a2, a3}, 3'b111);
    check_outputs("R7");

    // R8 suspend
    susp = 1'b1;
    repeat (4) @(negedge clk);
    check_outputs("R8");
    wr_txn(7'h28, 8'hAA, 8'h40, a1, a2, a3); mdl_bri = 8'h40;
    check_outputs("R8");
    rd_txn(8'hAA, rd, ok); chk("R8 stored", rd, 8'h40);
    susp = 1'b0;
    repeat (4) @(negedge clk);
    check_outputs("R8");

    // Random mix (R3 R4 R6)
    for (int n = 0; n < 24; n++) begin
      logic sel, do_rd;
      logic [7:0] v;
      sel   = 1'($urandom);
      do_rd = 1'($urandom);
      v     = 8'($urandom);
      if (do_rd) begin
        rd_txn(sel ? 8'hAA : 8'hA9, rd, ok);
        chk("R6 random read", rd, sel ? mdl_bri : mdl_con);
      end else begin
        wr_txn(7'h28, sel ? 8'hAA : 8'hA9, v, a1, a2, a3);
        if (sel) mdl_bri = v; else mdl_con = v;
        chk(sel ? "R4 random acks" : "R3 random acks", {a1, a2, a3}, 3'b111);
        check_outputs(sel ? "R4" : "R3");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule